// File: doc/BRIEF.md
# Double-Data-Rate Two-Word Burst SRAM Model

This block is a synthesizable, cycle-accurate model of a pipelined static RAM with a double-data-rate interface. It holds a small word array whose size is set by a parameter. It runs on one internal clock at twice the interface rate, so every edge of that clock stands for one interface half-cycle. A toggling phase bit marks which internal edges are rising edges of the interface clock. Commands are taken only on those edges. Each command moves a pair of words: one in each half of an interface cycle.

Write data arrives one interface cycle after its command. Every word carries its own active-low byte selects. Read data comes back after two and a half interface cycles in normal mode, or after one cycle when the delay-locked-loop enable input is low. A valid flag leads the read data by half a cycle. An output enable marks the halves in which words are driven. An echo strobe follows the interface clock phase.

A read reflects every write whose command came before it, even when the two commands are adjacent. It reflects no write issued after it.

Top module: `ddr_burst_sram`

## Requirements
- R1: A command is accepted only on an internal edge where the interface phase is a rising one: the first edge after reset and every second edge after that. It needs `ld_n` low at that edge. `rw`=1 selects a read and `rw`=0 a write. `ld_n`, `rw` and `addr` are ignored on all other edges.
- R2: With `ld_n` high on a rising-phase edge, no access starts. The outputs stay idle and the array is unchanged.
- R3: For a write accepted on edge t, word 0 is sampled from `wd`/`bws_n` at edge t+2 and stored at `addr`. Word 1 is sampled at edge t+3 and stored at `addr` with bit 0 inverted. A read returns its two words in the same order.
- R4: `bws_n[i]` low stores byte lane i (bits 9i+8..9i) of that word. High keeps the stored lane. Each word of a burst is masked independently.
- R5: With `dll_en`=1, a read accepted on edge t drives word 0 on `q` after edge t+5 and word 1 after edge t+6.
- R6: With `dll_en`=0, a read accepted on edge t drives word 0 after edge t+2 and word 1 after edge t+3.
- R7: `q_vld` is high from one half-cycle before word 0 of a read through the half in which word 0 is driven.
- R8: `q_oe` is high exactly in the halves where a read word is driven. `q` is all zeros whenever `q_oe` is low.
- R9: `echo` is high in each half that begins with a rising-phase edge and low in the other halves.
- R10: A read accepted right after a write to the same word pair returns the newly written bytes, merged with the unmasked old bytes.
- R11: A read accepted right before a write to the same word pair returns the contents as they were before that write.
- R12: While `rst` is high, `q`, `q_oe`, `q_vld` and `echo` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, two edges per interface cycle |
| rst | input | 1 | Synchronous reset, active high |
| ld_n | input | 1 | Start an access, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 8 | Word address of the burst |
| dll_en | input | 1 | 1 = 2.5-cycle read latency, 0 = 1.0-cycle latency |
| wd | input | 18 | Write data word |
| bws_n | input | 2 | Active-low byte write selects for the current word |
| q | output | 18 | Read data word |
| q_oe | output | 1 | High while a read word is driven |
| q_vld | output | 1 | Read-valid flag, leading the data by half a cycle |
| echo | output | 1 | Echo strobe following the interface phase |

## Verification
The assertions assume that `dll_en` changes only while no read is in flight. Changing the latency mid-burst would split a valid window from its data. The bench therefore drains the pipe with idle cycles before every mode change. The assertions also assume the array depth is a power of two, so a burst partner address is always in range. The stimulus fills every word before its first read. It also drives `ld_n` low with random `rw` and `addr` on the off-phase edges, to show those edges are ignored.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

    // Read latency counted in internal half-cycle edges.
    localparam int LAT_NORM_H   = 5;
    localparam int LAT_LEGACY_H = 2;

    // Pipe stage in which both read words are copied out of the array.
    // It must equal LAT_LEGACY_H, so that the short mode can take
    // word 0 straight from the array read port.
    localparam int SNAP_STAGE   = 2;

    // Number of write-pipe stages: word 0 at +2 and word 1 at +3.
    localparam int WR_STAGES    = 3;

endpackage

// File: rtl/ddrb_ctrl.sv
module ddrb_ctrl
    import ddrb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd,
    input  logic [NB-1:0] bws_n,
    output logic          phase_o,
    output logic          rd_go,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [NB-1:0] wr_be
);

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
    } wslot_t;

    typedef struct packed {
        logic                       phase;
        wslot_t [WR_STAGES-1:0]     ws;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic     accept_c;
    logic     wr_go_c;

    always_comb begin
        s_d      = s_q;
        accept_c = !s_q.phase && !ld_n;
        rd_go    = accept_c && rw;
        wr_go_c  = accept_c && !rw;

        s_d.phase   = !s_q.phase;
        s_d.ws[0].v = wr_go_c;
        s_d.ws[0].a = addr;
        for (int k = 1; k < WR_STAGES; k++) begin
            s_d.ws[k] = s_q.ws[k-1];
        end

        wr_en   = 1'b0;
        wr_addr = '0;
        wr_be   = '0;
        if (s_q.ws[1].v) begin
            wr_en   = 1'b1;
            wr_addr = s_q.ws[1].a;
            wr_be   = ~bws_n;
        end else if (s_q.ws[2].v) begin
            wr_en   = 1'b1;
            wr_addr = {s_q.ws[2].a[AW-1:1], ~s_q.ws[2].a[0]};
            wr_be   = ~bws_n;
        end
    end

    assign wr_data = wd;
    assign rd_addr = addr;
    assign phase_o = s_q.phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R1: a read is never accepted on two edges in a row.
    a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> !rd_go);

    // R3: the second word of a write burst goes to the partner address.
    a_r3_partner_word: assert property (@(posedge clk) disable iff (rst)
        (wr_en && s_q.ws[1].v) |=> (wr_en && (wr_addr == ($past(wr_addr) ^ AW'(1)))));

endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int BW    = 9,
    parameter int NB    = 2,
    parameter int DW    = 18
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NB-1:0] wr_be,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    output logic [DW-1:0] rd0,
    output logic [DW-1:0] rd1
);

    // One storage array per byte lane, so each lane has its own write enable.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                lane_mem[wr_addr] <= wr_data[b*BW +: BW];
            end
        end

        assign rd0[b*BW +: BW] = lane_mem[ra0];
        assign rd1[b*BW +: BW] = lane_mem[ra1];
    end

endmodule

// File: rtl/ddrb_rdpipe.sv
module ddrb_rdpipe
    import ddrb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dll_en,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] ra0,
    output logic [AW-1:0] ra1,
    input  logic [DW-1:0] rd0,
    input  logic [DW-1:0] rd1,
    output logic [DW-1:0] q,
    output logic          q_oe,
    output logic          q_vld
);

    localparam int NST = LAT_NORM_H + 1;
    localparam int LN  = LAT_NORM_H;
    localparam int LL  = LAT_LEGACY_H;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
    } stage_t;

    typedef struct packed {
        stage_t [NST-1:0] st;
        logic [DW-1:0]    q;
        logic             oe;
        logic             vld;
    } rd_st_t;

    rd_st_t s_d, s_q;
    logic   w0_c, w1_c, pre_c;
    logic [DW-1:0] w0_data_c;

    always_comb begin
        s_d = s_q;

        s_d.st[0].v  = rd_go;
        s_d.st[0].a  = rd_addr;
        s_d.st[0].d0 = '0;
        s_d.st[0].d1 = '0;
        for (int k = 1; k < NST; k++) begin
            s_d.st[k] = s_q.st[k-1];
        end
        s_d.st[SNAP_STAGE].d0 = rd0;
        s_d.st[SNAP_STAGE].d1 = rd1;

        if (dll_en) begin
            pre_c     = s_q.st[LN-2].v;
            w0_c      = s_q.st[LN-1].v;
            w1_c      = s_q.st[LN].v;
            w0_data_c = s_q.st[LN-1].d0;
        end else begin
            pre_c     = s_q.st[LL-2].v;
            w0_c      = s_q.st[LL-1].v;
            w1_c      = s_q.st[LL].v;
            w0_data_c = rd0;
        end

        s_d.vld = pre_c || w0_c;
        s_d.oe  = w0_c || w1_c;
        if (w0_c) begin
            s_d.q = w0_data_c;
        end else if (w1_c) begin
            s_d.q = dll_en ? s_q.st[LN].d1 : s_q.st[LL].d1;
        end else begin
            s_d.q = '0;
        end
    end

    assign ra0   = s_q.st[SNAP_STAGE-1].a;
    assign ra1   = {s_q.st[SNAP_STAGE-1].a[AW-1:1], ~s_q.st[SNAP_STAGE-1].a[0]};
    assign q     = s_q.q;
    assign q_oe  = s_q.oe;
    assign q_vld = s_q.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: a valid flag that is not yet covering data is followed by data.
    a_r7_vld_leads_data: assert property (@(posedge clk) disable iff (rst)
        (s_q.vld && !s_q.oe) |=> s_q.oe);

    // R8: data never starts without the valid flag in the half before it.
    a_r8_oe_after_vld: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.oe) |-> $past(s_q.vld));

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram #(
    parameter int DEPTH  = 256,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ld_n,
    input  logic                       rw,
    input  logic [$clog2(DEPTH)-1:0]   addr,
    input  logic                       dll_en,
    input  logic [BYTE_W*NBYTES-1:0]   wd,
    input  logic [NBYTES-1:0]          bws_n,
    output logic [BYTE_W*NBYTES-1:0]   q,
    output logic                       q_oe,
    output logic                       q_vld,
    output logic                       echo
);

    localparam int AW = $clog2(DEPTH);
    localparam int DW = BYTE_W * NBYTES;

    logic          rd_go;
    logic [AW-1:0] rd_addr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [NBYTES-1:0] wr_be;
    logic [AW-1:0] ra0, ra1;
    logic [DW-1:0] rd0, rd1;

    ddrb_ctrl #(.AW(AW), .DW(DW), .NB(NBYTES)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ld_n    (ld_n),
        .rw      (rw),
        .addr    (addr),
        .wd      (wd),
        .bws_n   (bws_n),
        .phase_o (echo),
        .rd_go   (rd_go),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be)
    );

    ddrb_array #(.DEPTH(DEPTH), .AW(AW), .BW(BYTE_W), .NB(NBYTES), .DW(DW)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .ra0     (ra0),
        .ra1     (ra1),
        .rd0     (rd0),
        .rd1     (rd1)
    );

    ddrb_rdpipe #(.AW(AW), .DW(DW)) u_rdpipe (
        .clk     (clk),
        .rst     (rst),
        .dll_en  (dll_en),
        .rd_go   (rd_go),
        .rd_addr (rd_addr),
        .ra0     (ra0),
        .ra1     (ra1),
        .rd0     (rd0),
        .rd1     (rd1),
        .q       (q),
        .q_oe    (q_oe),
        .q_vld   (q_vld)
    );

endmodule

// File: tb/ddr_burst_sram_tb.sv
module ddr_burst_sram_tb;

    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int DW    = 18;
    localparam int RING  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_n = 1'b1;
    logic          rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          dll_en = 1'b1;
    logic [DW-1:0] wd = '0;
    logic [1:0]    bws_n = 2'b11;
    logic [DW-1:0] q;
    logic          q_oe, q_vld, echo;

    always #5 clk = ~clk;

    ddr_burst_sram #(.DEPTH(DEPTH), .BYTE_W(9), .NBYTES(2)) u_dut (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rw(rw), .addr(addr),
        .dll_en(dll_en), .wd(wd), .bws_n(bws_n),
        .q(q), .q_oe(q_oe), .q_vld(q_vld), .echo(echo)
    );

    int nvec = 0;
    int nfail = 0;
    int e = 0;
    bit done = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic          exp_oe  [RING];
    logic          exp_vld [RING];
    logic [DW-1:0] exp_q   [RING];
    logic          sch_w   [RING];
    logic [DW-1:0] sch_d   [RING];
    logic [1:0]    sch_b   [RING];

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 1337 + salt * 4099 + 341);
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [1:0] b);
        logic [DW-1:0] r;
        r = old;
        if (!b[0]) r[8:0]  = nw[8:0];
        if (!b[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s edge %0d actual %0h expected %0h", tag, e, act, expv);
        end
    endtask

    // Compare the outputs seen after edge ed with what was scheduled for it.
    task automatic check_slot(input int ed);
        int s;
        s = ed % RING;
        chk(q_oe == exp_oe[s], "R8 q_oe", 32'(q_oe), 32'(exp_oe[s]));
        chk(q_vld == exp_vld[s], "R7 q_vld", 32'(q_vld), 32'(exp_vld[s]));
        if (dll_en) chk(q == exp_q[s], "R5 q", 32'(q), 32'(exp_q[s]));
        else        chk(q == exp_q[s], "R6 q", 32'(q), 32'(exp_q[s]));
        chk(echo == ((ed % 2) == 0), "R9 echo", 32'(echo), 32'((ed % 2) == 0));
        exp_oe[s]  = 1'b0;
        exp_vld[s] = 1'b0;
        exp_q[s]   = '0;
    endtask

    // Drive the inputs for edge e, let it pass, then check its result.
    task automatic half(input logic ldn, input logic rwv, input logic [AW-1:0] a);
        int s;
        s = e % RING;
        ld_n = ldn;
        rw   = rwv;
        addr = a;
        if (sch_w[s]) begin
            wd    = sch_d[s];
            bws_n = sch_b[s];
            sch_w[s] = 1'b0;
        end else begin
            wd    = DW'(e * 7919 + 5);
            bws_n = 2'(e);
        end
        @(negedge clk);
        check_slot(e);
        e++;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                            input logic [DW-1:0] d1, input logic [1:0] b0,
                            input logic [1:0] b1);
        int s;
        s = (e + 2) % RING;
        sch_w[s] = 1'b1; sch_d[s] = d0; sch_b[s] = b0;
        s = (e + 3) % RING;
        sch_w[s] = 1'b1; sch_d[s] = d1; sch_b[s] = b1;
        ref_mem[a]         = merge(ref_mem[a], d0, b0);
        ref_mem[a ^ 8'd1]  = merge(ref_mem[a ^ 8'd1], d1, b1);
        half(1'b0, 1'b0, a);
        half(1'b0, 1'b1, ~a);          // R1: off-phase edge must be ignored
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int lat;
        lat = dll_en ? 5 : 2;
        exp_vld[(e + lat - 1) % RING] = 1'b1;
        exp_vld[(e + lat) % RING]     = 1'b1;
        exp_oe[(e + lat) % RING]      = 1'b1;
        exp_q[(e + lat) % RING]       = ref_mem[a];
        exp_oe[(e + lat + 1) % RING]  = 1'b1;
        exp_q[(e + lat + 1) % RING]   = ref_mem[a ^ 8'd1];
        half(1'b0, 1'b1, a);
        half(1'b0, 1'b0, a ^ 8'h55);   // R1: off-phase edge must be ignored
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            half(1'b1, 1'(i), AW'(i * 3));   // R2: ld_n high on the K edge
            half(1'b0, 1'b0, AW'(i * 5));
        end
    endtask

    task automatic set_mode(input logic m);
        idle(5);
        dll_en = m;
        idle(1);
    endtask

    initial begin
        for (int i = 0; i < RING; i++) begin
            exp_oe[i] = 0; exp_vld[i] = 0; exp_q[i] = '0; sch_w[i] = 0;
            sch_d[i] = '0; sch_b[i] = 2'b11;
        end
        repeat (3) @(negedge clk);
        // R12: outputs held low in reset
        chk(q_oe == 0 && q_vld == 0, "R12 flags", {30'd0, q_oe, q_vld}, 0);
        chk(q == '0, "R12 q", 32'(q), 0);
        chk(echo == 0, "R12 echo", 32'(echo), 0);
        rst = 1'b0;

        // R5/R3: fill the array, then read every pair back in normal mode
        for (int a = 0; a < DEPTH; a += 2)
            do_write(AW'(a), pat(a, 0), pat(a + 1, 0), 2'b00, 2'b00);
        for (int a = 0; a < DEPTH; a += 2) do_read(AW'(a));
        // R3: an odd start address returns the odd word first
        for (int a = 1; a < DEPTH; a += 4) do_read(AW'(a));

        // R4: every byte-select combination on both words
        for (int m = 0; m < 16; m++) begin
            do_write(AW'(64 + 2 * m), pat(m, 7), pat(m, 9), 2'(m), 2'(m >> 2));
            do_read(AW'(64 + 2 * m));
            do_read(AW'(65 + 2 * m));
        end

        // R2: idle edges with noise, then confirm contents are untouched
        idle(6);
        for (int a = 0; a < 16; a += 2) do_read(AW'(a));

        // R10: read right after a masked write to the same pair
        for (int i = 0; i < 8; i++) begin
            do_write(AW'(128 + 4 * i), pat(i, 11), pat(i, 13), 2'(i), 2'(3 - (i % 4)));
            do_read(AW'(128 + 4 * i));
        end
        // R11: write right after a read of the same pair
        for (int i = 0; i < 8; i++) begin
            do_read(AW'(160 + 2 * i));
            do_write(AW'(160 + 2 * i), pat(i, 17), pat(i, 19), 2'b00, 2'b00);
            do_read(AW'(160 + 2 * i));
        end

        // R6: short-latency mode
        set_mode(1'b0);
        for (int a = 0; a < DEPTH; a += 8) do_read(AW'(a));
        for (int i = 0; i < 8; i++) begin
            do_write(AW'(200 + 2 * i), pat(i, 23), pat(i, 29), 2'(i + 1), 2'(i));
            do_read(AW'(200 + 2 * i));                   // R10 in short mode
            do_write(AW'(200 + 2 * i), pat(i, 31), pat(i, 37), 2'b00, 2'b10);
            do_read(AW'(201 + 2 * i));                   // R11 ordering
        end
        idle(3);
        for (int i = 0; i < 16; i++) begin
            if (i % 3 == 0) do_write(AW'(i * 13), pat(i, 41), pat(i, 43), 2'(i), 2'(i + 2));
            else            do_read(AW'(i * 13));
        end

        // back to normal mode with mixed traffic
        set_mode(1'b1);
        for (int i = 0; i < 24; i++) begin
            if (i % 4 == 1) do_write(AW'(i * 29), pat(i, 47), pat(i, 53), 2'(i), 2'(i >> 1));
            else            do_read(AW'(i * 29));
        end
        idle(6);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog expired at edge %0d actual 0 expected 1", e);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule